// File: doc/BRIEF.md
# Raster Timing Generator with Separate Data-Valid Window

This block produces the raster timing for a display interface. From a set of programmable horizontal and vertical sizes it drives a horizontal sync, a vertical sync, a display-window enable, an active-picture enable and a data-valid enable. The position inside a frame is tracked in pixel clocks from the first clock of the vertical sync pulse. Vertical window edges are therefore absolute pixel offsets, and a programmable line skew can move them by whole pixels.

The data-valid enable is kept apart from the picture windows. When compressed transport is selected, its width comes from the number of compressed bytes per line. When a double-width pixel bus is selected, the width is halved. A packetised-link style (`dp_style`) pulls the vertical display edges inward by the horizontal blanking amounts. In that style the horizontal display window takes the active-picture window. A separate HDMI style makes the sync polarity depend on the vertical resolution.

All timing inputs are plain level pins. The generator takes a snapshot of them when it is enabled and again on the last clock of every frame. A change made in the middle of a frame therefore takes effect on the next frame. Nothing on the block streams data, so it has no valid/ready handshake and applies no back-pressure.

Top module: `vtg_raster_top`

## Requirements
- R1: After reset and while `enable` is low, `display_en`, `active_en` and `data_en` are low and both syncs stay at their inactive level. On the first clock edge that samples `enable` high, the frame position becomes 0 (the first clock of the horizontal and vertical sync pulses). Dropping `enable` returns the block to this idle state on the next edge.
- R2: A line lasts `h_sync_w + h_back + h_act + h_front` clocks, and a frame lasts `v_sync_w + v_back + v_act + v_front` lines. The horizontal sync is active for the first `h_sync_w` clocks of each line. The vertical sync is active for the first `v_sync_w` lines of each frame.
- R3: Horizontally, the display window covers line positions `h_sync_w + h_back` through `line_length - h_front - 1`. Vertically, it covers frame positions `(v_sync_w + v_back) * line_length + line_skew` through `(frame_lines - v_front) * line_length + line_skew - 1`. `display_en` is high where both hold.
- R4: `active_en` is high for line positions `h_sync_w + h_back` through that value `+ h_res - 1`. Vertically it starts at the vertical display start and lasts `v_res * line_length` clocks.
- R5: Without compression, the data width is `h_act / 2` (rounded down) when the wide bus is on and `dp_style` is off. In every other case it is `h_act`.
- R6: With compression, the data width is `comp_bytes / 3` rounded up. When the wide bus is also on, it is `comp_bytes / 6` rounded up.
- R7: Separate data timing applies unless compression is on and the wide bus is off. When it applies, `data_en` is high inside the vertical display window for line positions `h_sync_w + h_back` through that value `+ data_width - 1`. When it does not apply, `data_en` equals `display_en`.
- R8: With `dp_style` set, the vertical display start moves later by `h_sync_w + h_back`, and the vertical display end moves earlier by `h_front`. The horizontal display window then becomes the active horizontal window.
- R9: With `dp_style`, compression and separate data timing all in effect, the data window runs from line position `h_sync_w + h_back` through that value `+ dto_extra`, inclusive.
- R10: With `hdmi_style` set, both syncs are active-high when `v_res >= 720` and active-low otherwise. Without it, both syncs are active-high. The idle level is the inverse of the active level.
- R11: The block samples all timing inputs only on the enabling edge and on the last clock of each frame. Changes made inside a frame leave every output of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| h_sync_w | input | HW | Horizontal sync pulse width, clocks |
| h_back | input | HW | Horizontal back porch, clocks |
| h_act | input | HW | Horizontal active width, clocks |
| h_front | input | HW | Horizontal front porch, clocks |
| h_res | input | HW | Horizontal picture resolution |
| v_sync_w | input | VW | Vertical sync pulse width, lines |
| v_back | input | VW | Vertical back porch, lines |
| v_act | input | VW | Vertical active height, lines |
| v_front | input | VW | Vertical front porch, lines |
| v_res | input | VW | Vertical picture resolution |
| line_skew | input | HW | Skew added to vertical edges, clocks |
| comp_on | input | 1 | Compressed transport |
| wide_on | input | 1 | Double-width pixel bus |
| dp_style | input | 1 | Packetised-link timing style |
| hdmi_style | input | 1 | Resolution-dependent sync polarity |
| comp_bytes | input | CBW | Compressed bytes per line |
| dto_extra | input | HW | Extra data cycles in link style with compression |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| display_en | output | 1 | Display window enable |
| active_en | output | 1 | Active picture enable |
| data_en | output | 1 | Data-valid enable |

## Verification
Two things can happen in the same cycle: the frame wraps and takes a new snapshot of the timing inputs, and those inputs change. The bench changes the mode and geometry inputs at arbitrary frame positions, some of them close to the wrap. Its model keeps the old snapshot until the wrap and switches only then. Every output is compared on every clock, so a snapshot taken one clock early or late shows up as a wrong window or polarity in the first clocks of the next frame. The sweep also covers all eight combinations of compression, wide bus and link style on two geometries, several skews, and both sides of the polarity threshold.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef struct packed {
    logic comp;
    logic wide;
    logic dp;
    logic hdmi;
  } vtg_mode_t;

  function automatic int unsigned ceil_div(input int unsigned num,
                                           input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/vtg_frame_counter.sv
module vtg_frame_counter #(
  parameter  int HW  = 12,
  parameter  int VW  = 12,
  parameter  int CW  = 8,
  localparam int HPW = HW + 2,
  localparam int VPW = VW + 2,
  localparam int PW  = HPW + VPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [CW-1:0]  cfg_in,
  input  logic [HPW-1:0] hper,
  input  logic [VPW-1:0] vper,
  output logic           running,
  output logic [CW-1:0]  cfg_q,
  output logic [HPW-1:0] hcnt,
  output logic [VPW-1:0] line,
  output logic [PW-1:0]  pos
);

  logic line_last;
  logic frame_last;

  assign line_last  = (hcnt == hper - HPW'(1));
  assign frame_last = line_last && (line == vper - VPW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cfg_q   <= '0;
      hcnt    <= '0;
      line    <= '0;
      pos     <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      hcnt    <= '0;
      line    <= '0;
      pos     <= '0;
    end else if (!running || frame_last) begin
      running <= 1'b1;
      cfg_q   <= cfg_in;
      hcnt    <= '0;
      line    <= '0;
      pos     <= '0;
    end else begin
      pos <= pos + PW'(1);
      if (line_last) begin
        hcnt <= '0;
        line <= line + VPW'(1);
      end else begin
        hcnt <= hcnt + HPW'(1);
      end
    end
  end

  // R11: snapshot is held for the whole frame
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(frame_last)) |-> (cfg_q == $past(cfg_q)));

  // R2: line position never reaches the line length
  assert_hcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hcnt < hper));

  // R1: a run always begins at the first clock of the sync pulses
  assert_start_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (pos == '0 && hcnt == '0 && line == '0));

endmodule

// File: rtl/vtg_geom.sv
module vtg_geom
  import vtg_pkg::*;
#(
  parameter  int HW           = 12,
  parameter  int VW           = 12,
  parameter  int CBW          = 16,
  parameter  int HI_POL_LINES = 720,
  localparam int HPW          = HW + 2,
  localparam int VPW          = VW + 2,
  localparam int XW           = HPW + 1,
  localparam int PW           = HPW + VPW
) (
  input  logic [HW-1:0]  hsw,
  input  logic [HW-1:0]  hbp,
  input  logic [HW-1:0]  hact,
  input  logic [HW-1:0]  hfp,
  input  logic [HW-1:0]  hres,
  input  logic [VW-1:0]  vsw,
  input  logic [VW-1:0]  vbp,
  input  logic [VW-1:0]  vact,
  input  logic [VW-1:0]  vfp,
  input  logic [VW-1:0]  vres,
  input  logic [HW-1:0]  skew,
  input  logic [HW-1:0]  extra,
  input  logic [CBW-1:0] cbytes,
  input  vtg_mode_t      mode,
  output logic [HPW-1:0] hper,
  output logic [VPW-1:0] vper,
  output logic [XW-1:0]  h_start,
  output logic [XW-1:0]  h_disp_x,
  output logic [XW-1:0]  h_act_x,
  output logic [XW-1:0]  h_data_x,
  output logic [PW-1:0]  v_start,
  output logic [PW-1:0]  v_disp_x,
  output logic [PW-1:0]  v_act_x,
  output logic           sep_data,
  output logic           act_high
);

  logic [XW-1:0] data_w;
  logic [XW-1:0] h_nat_x;
  logic [PW-1:0] v_base;
  logic [PW-1:0] v_end_base;

  always_comb begin
    hper = HPW'(hsw) + HPW'(hbp) + HPW'(hact) + HPW'(hfp);
    vper = VPW'(vsw) + VPW'(vbp) + VPW'(vact) + VPW'(vfp);

    h_start = XW'(hsw) + XW'(hbp);
    h_act_x = h_start + XW'(hres);
    h_nat_x = XW'(hper) - XW'(hfp);
    h_disp_x = mode.dp ? h_act_x : h_nat_x;

    if (mode.comp) begin
      if (mode.wide) data_w = XW'(ceil_div(32'(cbytes), 32'd6));
      else           data_w = XW'(ceil_div(32'(cbytes), 32'd3));
    end else if (mode.wide && !mode.dp) begin
      data_w = XW'(hact >> 1);
    end else begin
      data_w = XW'(hact);
    end

    if (mode.dp && mode.comp) h_data_x = h_start + XW'(extra) + XW'(1);
    else                      h_data_x = h_start + data_w;

    sep_data = !mode.comp || mode.wide;
    act_high = !mode.hdmi || (32'(vres) >= 32'(HI_POL_LINES));

    v_base     = (PW'(vsw) + PW'(vbp)) * PW'(hper) + PW'(skew);
    v_end_base = (PW'(vper) - PW'(vfp)) * PW'(hper) + PW'(skew);
    if (mode.dp) begin
      v_start  = v_base + PW'(hsw) + PW'(hbp);
      v_disp_x = v_end_base - PW'(hfp);
    end else begin
      v_start  = v_base;
      v_disp_x = v_end_base;
    end
    v_act_x = v_start + PW'(vres) * PW'(hper);
  end

endmodule

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter  int HW  = 12,
  parameter  int VW  = 12,
  localparam int HPW = HW + 2,
  localparam int VPW = VW + 2,
  localparam int XW  = HPW + 1,
  localparam int PW  = HPW + VPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic [HPW-1:0] hcnt,
  input  logic [VPW-1:0] line,
  input  logic [PW-1:0]  pos,
  input  logic [HW-1:0]  hsw,
  input  logic [VW-1:0]  vsw,
  input  logic [XW-1:0]  h_start,
  input  logic [XW-1:0]  h_disp_x,
  input  logic [XW-1:0]  h_act_x,
  input  logic [XW-1:0]  h_data_x,
  input  logic [PW-1:0]  v_start,
  input  logic [PW-1:0]  v_disp_x,
  input  logic [PW-1:0]  v_act_x,
  input  logic           sep_data,
  input  logic           act_high,
  output logic           hsync,
  output logic           vsync,
  output logic           display_en,
  output logic           active_en,
  output logic           data_en
);

  logic [XW-1:0] hx;
  logic hs_on, vs_on;
  logic in_hdisp, in_hact, in_hdata;
  logic in_vdisp, in_vact;

  always_comb begin
    hx       = XW'(hcnt);
    hs_on    = running && (hcnt < HPW'(hsw));
    vs_on    = running && (line < VPW'(vsw));
    in_hdisp = (hx >= h_start) && (hx < h_disp_x);
    in_hact  = (hx >= h_start) && (hx < h_act_x);
    in_hdata = (hx >= h_start) && (hx < h_data_x);
    in_vdisp = (pos >= v_start) && (pos < v_disp_x);
    in_vact  = (pos >= v_start) && (pos < v_act_x);

    hsync      = act_high ? hs_on : !hs_on;
    vsync      = act_high ? vs_on : !vs_on;
    display_en = running && in_hdisp && in_vdisp;
    active_en  = running && in_hact && in_vact;
    data_en    = running && in_vdisp && (sep_data ? in_hdata : in_hdisp);
  end

  // R1: nothing is enabled while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!display_en && !active_en && !data_en));

  // R10: both syncs rest at the same inactive level when idle
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (hsync == vsync));

endmodule

// File: rtl/vtg_raster_top.sv
module vtg_raster_top
  import vtg_pkg::*;
#(
  parameter int HW           = 12,
  parameter int VW           = 12,
  parameter int CBW          = 16,
  parameter int HI_POL_LINES = 720
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [HW-1:0]  h_sync_w,
  input  logic [HW-1:0]  h_back,
  input  logic [HW-1:0]  h_act,
  input  logic [HW-1:0]  h_front,
  input  logic [HW-1:0]  h_res,
  input  logic [VW-1:0]  v_sync_w,
  input  logic [VW-1:0]  v_back,
  input  logic [VW-1:0]  v_act,
  input  logic [VW-1:0]  v_front,
  input  logic [VW-1:0]  v_res,
  input  logic [HW-1:0]  line_skew,
  input  logic           comp_on,
  input  logic           wide_on,
  input  logic           dp_style,
  input  logic           hdmi_style,
  input  logic [CBW-1:0] comp_bytes,
  input  logic [HW-1:0]  dto_extra,
  output logic           hsync,
  output logic           vsync,
  output logic           display_en,
  output logic           active_en,
  output logic           data_en
);

  localparam int HPW = HW + 2;
  localparam int VPW = VW + 2;
  localparam int XW  = HPW + 1;
  localparam int PW  = HPW + VPW;
  localparam int CW  = 7 * HW + 5 * VW + CBW + 4;

  vtg_mode_t      mode_in, mode_q;
  logic [CW-1:0]  cfg_in, cfg_q;
  logic [HW-1:0]  q_hsw, q_hbp, q_hact, q_hfp, q_hres, q_skew, q_extra;
  logic [VW-1:0]  q_vsw, q_vbp, q_vact, q_vfp, q_vres;
  logic [CBW-1:0] q_cbytes;

  logic           running;
  logic [HPW-1:0] hcnt, hper;
  logic [VPW-1:0] line, vper;
  logic [PW-1:0]  pos;
  logic [XW-1:0]  h_start, h_disp_x, h_act_x, h_data_x;
  logic [PW-1:0]  v_start, v_disp_x, v_act_x;
  logic           sep_data, act_high;

  assign mode_in = '{comp: comp_on, wide: wide_on, dp: dp_style, hdmi: hdmi_style};
  assign cfg_in  = {mode_in, comp_bytes, dto_extra, line_skew,
                    v_res, v_front, v_act, v_back, v_sync_w,
                    h_res, h_front, h_act, h_back, h_sync_w};
  assign {mode_q, q_cbytes, q_extra, q_skew,
          q_vres, q_vfp, q_vact, q_vbp, q_vsw,
          q_hres, q_hfp, q_hact, q_hbp, q_hsw} = cfg_q;

  vtg_frame_counter #(.HW(HW), .VW(VW), .CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cfg_in  (cfg_in),
    .hper    (hper),
    .vper    (vper),
    .running (running),
    .cfg_q   (cfg_q),
    .hcnt    (hcnt),
    .line    (line),
    .pos     (pos)
  );

  vtg_geom #(.HW(HW), .VW(VW), .CBW(CBW), .HI_POL_LINES(HI_POL_LINES)) u_geom (
    .hsw      (q_hsw),
    .hbp      (q_hbp),
    .hact     (q_hact),
    .hfp      (q_hfp),
    .hres     (q_hres),
    .vsw      (q_vsw),
    .vbp      (q_vbp),
    .vact     (q_vact),
    .vfp      (q_vfp),
    .vres     (q_vres),
    .skew     (q_skew),
    .extra    (q_extra),
    .cbytes   (q_cbytes),
    .mode     (mode_q),
    .hper     (hper),
    .vper     (vper),
    .h_start  (h_start),
    .h_disp_x (h_disp_x),
    .h_act_x  (h_act_x),
    .h_data_x (h_data_x),
    .v_start  (v_start),
    .v_disp_x (v_disp_x),
    .v_act_x  (v_act_x),
    .sep_data (sep_data),
    .act_high (act_high)
  );

  vtg_window #(.HW(HW), .VW(VW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .hcnt       (hcnt),
    .line       (line),
    .pos        (pos),
    .hsw        (q_hsw),
    .vsw        (q_vsw),
    .h_start    (h_start),
    .h_disp_x   (h_disp_x),
    .h_act_x    (h_act_x),
    .h_data_x   (h_data_x),
    .v_start    (v_start),
    .v_disp_x   (v_disp_x),
    .v_act_x    (v_act_x),
    .sep_data   (sep_data),
    .act_high   (act_high),
    .hsync      (hsync),
    .vsync      (vsync),
    .display_en (display_en),
    .active_en  (active_en),
    .data_en    (data_en)
  );

endmodule

// File: tb/test_vtg_raster_top.sv
module test_vtg_raster_top;

  typedef struct packed {
    int hsw, hbp, hact, hfp, hres;
    int vsw, vbp, vact, vfp, vres;
    int skew, cb, extra;
    bit comp, wide, dp, hdmi;
  } tcfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  tcfg_t in_c, cur;
  logic hsync, vsync, display_en, active_en, data_en;

  int tests = 0;
  int fails = 0;
  int mpos = 0;
  bit mrun = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vtg_raster_top i_vtg_raster_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .h_sync_w   (12'(in_c.hsw)),
    .h_back     (12'(in_c.hbp)),
    .h_act      (12'(in_c.hact)),
    .h_front    (12'(in_c.hfp)),
    .h_res      (12'(in_c.hres)),
    .v_sync_w   (12'(in_c.vsw)),
    .v_back     (12'(in_c.vbp)),
    .v_act      (12'(in_c.vact)),
    .v_front    (12'(in_c.vfp)),
    .v_res      (12'(in_c.vres)),
    .line_skew  (12'(in_c.skew)),
    .comp_on    (in_c.comp),
    .wide_on    (in_c.wide),
    .dp_style   (in_c.dp),
    .hdmi_style (in_c.hdmi),
    .comp_bytes (16'(in_c.cb)),
    .dto_extra  (12'(in_c.extra)),
    .hsync      (hsync),
    .vsync      (vsync),
    .display_en (display_en),
    .active_en  (active_en),
    .data_en    (data_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b pos=%0d", tag, act, exp, mpos);
    end
  endtask

  function automatic int hper(input tcfg_t c);
    return c.hsw + c.hbp + c.hact + c.hfp;
  endfunction

  function automatic int vlines(input tcfg_t c);
    return c.vsw + c.vbp + c.vact + c.vfp;
  endfunction

  task automatic compare();
    int hp, h, ln, hds, hde, ahe, vds, vde, ave, dw, dhe;
    bit hi, hs, vs, dv, dh, disp, act, dat;
    string note;
    hp = hper(cur);
    h  = (hp > 0) ? mpos % hp : 0;
    ln = (hp > 0) ? mpos / hp : 0;
    hi = !cur.hdmi || (cur.vres >= 720);
    hds = cur.hsw + cur.hbp;
    ahe = hds + cur.hres - 1;
    hde = hp - cur.hfp - 1;
    vds = (cur.vsw + cur.vbp) * hp + cur.skew;
    vde = (vlines(cur) - cur.vfp) * hp + cur.skew - 1;
    if (cur.dp) begin
      vds += cur.hsw + cur.hbp;
      vde -= cur.hfp;
      hde = ahe;
    end
    ave = vds + cur.vres * hp - 1;
    if (cur.comp) dw = cur.wide ? (cur.cb + 5) / 6 : (cur.cb + 2) / 3;
    else          dw = (cur.wide && !cur.dp) ? cur.hact / 2 : cur.hact;
    dhe = (cur.dp && cur.comp) ? hds + cur.extra : hds + dw - 1;
    hs   = mrun && (h < cur.hsw);
    vs   = mrun && (ln < cur.vsw);
    dv   = (mpos >= vds) && (mpos <= vde);
    dh   = (h >= hds) && (h <= hde);
    disp = mrun && dv && dh;
    act  = mrun && (h >= hds) && (h <= ahe) && (mpos >= vds) && (mpos <= ave);
    if (!cur.comp || cur.wide) dat = mrun && dv && (h >= hds) && (h <= dhe);
    else                       dat = disp;
    note = (mrun && (in_c != cur)) ? " R11" : "";
    if (!mrun) note = {note, " R1"};
    chk({"hsync R2 R10", note}, hsync, hi ? hs : !hs);
    chk({"vsync R2 R10", note}, vsync, hi ? vs : !vs);
    chk({cur.dp ? "display_en R8" : "display_en R3", note}, display_en, disp);
    chk({"active_en R4", note}, active_en, act);
    chk({"data_en R7 ",
         cur.comp ? (cur.dp ? "R9 R6" : "R6") : "R5", note}, data_en, dat);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (!enable) begin
        mrun = 1'b0;
        mpos = 0;
      end else if (!mrun || mpos == hper(cur) * vlines(cur) - 1) begin
        mrun = 1'b1;
        mpos = 0;
        cur  = in_c;
      end else begin
        mpos++;
      end
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    in_c = '{hsw: 2, hbp: 3, hact: 8, hfp: 2, hres: 6,
             vsw: 1, vbp: 2, vact: 4, vfp: 1, vres: 3,
             skew: 1, cb: 20, extra: 3,
             comp: 1'b0, wide: 1'b0, dp: 1'b0, hdmi: 1'b0};
    cur = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("reset hsync R1", hsync, 1'b0);
    chk("reset vsync R1", vsync, 1'b0);
    chk("reset display_en R1", display_en, 1'b0);
    chk("reset active_en R1", active_en, 1'b0);
    chk("reset data_en R1", data_en, 1'b0);
    rst_n = 1'b1;
    step(3);
    enable = 1'b1;
    // all eight mode mixes on the first geometry, changed mid-frame (R11)
    for (int m = 0; m < 8; m++) begin
      in_c.comp = m[0];
      in_c.wide = m[1];
      in_c.dp   = m[2];
      step(157);
    end
    // second geometry: odd active width, zero extra cycles
    in_c.hsw = 1; in_c.hbp = 1; in_c.hact = 5; in_c.hfp = 1; in_c.hres = 5;
    in_c.vsw = 2; in_c.vbp = 1; in_c.vact = 3; in_c.vfp = 2; in_c.vres = 3;
    in_c.cb = 7; in_c.extra = 0; in_c.skew = 0;
    for (int m = 0; m < 8; m++) begin
      in_c.comp = m[0];
      in_c.wide = m[1];
      in_c.dp   = m[2];
      step(101);
    end
    // skew sweep (R3, R8)
    for (int s = 0; s < 4; s++) begin
      in_c.skew = s * 3;
      in_c.dp   = s[0];
      in_c.comp = 1'b0;
      step(90);
    end
    // polarity threshold (R10)
    in_c.hdmi = 1'b1; in_c.vres = 720; step(130);
    in_c.vres = 719; step(130);
    in_c.hdmi = 1'b0; in_c.vres = 2; step(130);
    in_c.hdmi = 1'b1; step(60);
    // disable mid-frame, idle, restart from zero (R1)
    enable = 1'b0;
    step(6);
    enable = 1'b1;
    step(120);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule